// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a memory-mapped general-purpose I/O bank. It serves a parameterised number of pins, grouped into 32-bit words. Software reaches it through a plain 32-bit register port with a byte address. A write takes effect at the clock edge where the port is selected. A read returns its data one cycle after the request, held in a register. For each pin the bank keeps an output-enable bit and an output latch. Software changes the latch only through separate write-one-to-set and write-one-to-clear words. The current pin level can be read back after a two-flop synchroniser.

Each pin can be set to interrupt on edges or on levels. In edge mode, rising and falling detection are enabled on their own, and both may be on at once. In level mode, a polarity bit picks a high or a low trigger, and the status bit is set again on every clock while that level lasts. Triggers go into a status word that software clears by writing ones. A single interrupt line is raised when any status bit is set and its mask bit is 1. Pins whose wake bit is 1 also record their triggers in a wake status word, which is cleared the same way. The bank also holds two plain storage registers: a configuration word, and a per-pin filter-bypass bit that drives no logic here.

The register port is control traffic, not a data stream, so it has no handshake or back-pressure. Each group of registers starts at a fixed base. Word k of a group sits at base + 4k and holds pins 32k to 32k+31, with pin n at bit n mod 32. The group bases are: configuration 0x000, level 0x004, direction 0x01c, set 0x034, clear 0x04c, rising enable 0x064, falling enable 0x07c, filter bypass 0x094, interrupt mask 0x0ac, interrupt status 0x0c4, input type 0x300, level polarity 0x318, wake mask 0x400, wake status 0x418.

Top module: `gpio_bank_irq`

## Requirements
- R1: While reset is held and directly after it, every register reads 0, pin_oe and pin_out are all 0, and irq_out is 0.
- R2: Direction bit 1 drives the pin as an output (pin_oe high) and 0 makes it an input. pin_oe changes only at a write to a direction word.
- R3: Writing to the set word drives high each pin whose data bit is 1. Writing to the clear word drives each such pin low. Pins whose data bit is 0 keep their level. Both words read back as 0.
- R4: The level word returns the pin inputs after a two-flop synchroniser, so an input change is visible two clocks later. Writes to the level word have no effect.
- R5: With input type 0, a synchronised 0-to-1 change sets the pin's status bit when its rising enable is 1. A 1-to-0 change sets it when its falling enable is 1. With both enables set, both edges set the bit.
- R6: In edge mode, a change with the matching enable at 0 leaves the status bit at 0.
- R7: With input type 1, the status bit is set on every clock while the synchronised input equals the active level: high when the polarity bit is 0, low when it is 1. A clear written during that time has no effect. Once the level goes away the bit stays set until it is cleared.
- R8: Writing 1 to a status bit clears it, and bits written as 0 keep their value. A trigger in the same cycle wins over the clear.
- R9: irq_out is 1 exactly when some status bit and its mask bit are both 1.
- R10: A trigger on a pin whose wake mask bit is 1 sets its wake status bit. Pins with wake mask 0 do not set theirs. Writing ones clears wake status bits.
- R11: Pin n is bit n mod 32 of word n/32. Pin 36 therefore reports in bit 4 of the second status word, at 0x0c8, and leaves the first word untouched.
- R12: The configuration word and the filter-bypass words store and read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_in | input | NUM_PINS | Pin input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output latch per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench targets level-mode stickiness. A design that lets a clear win while the active level persists would read the status bit back as 0 instead of 1. It also targets a polarity-low pin that triggers as soon as the polarity bit is written. The bench checks that a write-ones clear removes only the addressed bits: a design that wrote the status word instead of clearing it would drop the untouched bit or set new ones. Further cases are a pin in the second word, which a wrong word index would report in word 0, and a wake mask that leaves a non-wake pin's wake bit at 0. The last is the interrupt line with the mask on the wrong bit, where a design ignoring the mask would raise the line.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_WORDS = 6;
  localparam int NUM_GRPS  = 13;

  localparam logic [11:0] OFS_CFG = 12'h000;

  typedef enum logic [3:0] {
    GRP_LEVEL, GRP_DIR, GRP_SET, GRP_CLR, GRP_RISE, GRP_FALL, GRP_BYP,
    GRP_MASK, GRP_STAT, GRP_TYPE, GRP_POL, GRP_WMASK, GRP_WSTAT, GRP_NONE
  } grp_e;

  localparam logic [11:0] GRP_BASE [NUM_GRPS] = '{
    12'h004, 12'h01c, 12'h034, 12'h04c, 12'h064, 12'h07c, 12'h094,
    12'h0ac, 12'h0c4, 12'h300, 12'h318, 12'h400, 12'h418
  };

  typedef struct packed {
    logic       hit;
    grp_e       grp;
    logic [2:0] word;
  } dec_t;

  function automatic dec_t decode_addr(input logic [11:0] a, input int words);
    dec_t d;
    logic [11:0] rel;
    d = '{hit: 1'b0, grp: GRP_NONE, word: 3'd0};
    for (int i = 0; i < NUM_GRPS; i++) begin
      rel = a - GRP_BASE[i];
      if (a >= GRP_BASE[i] && rel < 12'(4 * words) && a[1:0] == 2'b00) begin
        d.hit  = 1'b1;
        d.grp  = grp_e'(4'(i));
        d.word = rel[4:2];
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta   <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_word.sv
module gpio_word
  import gpio_bank_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  grp_e             grp,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] lvl,
  input  logic [REG_W-1:0] lvl_prev,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] out_q,
  output logic [REG_W-1:0] mask_q,
  output logic             irq_any
);
  logic [REG_W-1:0] rise_q, fall_q, byp_q, stat_q, type_q, pol_q, wmask_q, wstat_q;
  logic [REG_W-1:0] rising, falling, edge_hit, level_hit, trig, wd;
  logic [REG_W-1:0] stat_clr, wstat_clr;

  assign wd        = wdata & VALID;
  assign rising    = lvl & ~lvl_prev;
  assign falling   = ~lvl & lvl_prev;
  assign edge_hit  = (rise_q & rising) | (fall_q & falling);
  assign level_hit = lvl ^ pol_q;
  assign trig      = ((type_q & level_hit) | (~type_q & edge_hit)) & VALID;
  assign stat_clr  = (wr_en && grp == GRP_STAT)  ? wd : '0;
  assign wstat_clr = (wr_en && grp == GRP_WSTAT) ? wd : '0;
  assign irq_any   = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0; out_q <= '0; rise_q <= '0; fall_q <= '0; byp_q <= '0;
      mask_q <= '0; type_q <= '0; pol_q <= '0; wmask_q <= '0;
      stat_q <= '0; wstat_q <= '0;
    end else begin
      if (wr_en) begin
        case (grp)
          GRP_DIR:   dir_q   <= wd;
          GRP_SET:   out_q   <= out_q | wd;
          GRP_CLR:   out_q   <= out_q & ~wd;
          GRP_RISE:  rise_q  <= wd;
          GRP_FALL:  fall_q  <= wd;
          GRP_BYP:   byp_q   <= wd;
          GRP_MASK:  mask_q  <= wd;
          GRP_TYPE:  type_q  <= wd;
          GRP_POL:   pol_q   <= wd;
          GRP_WMASK: wmask_q <= wd;
          default: ;
        endcase
      end
      stat_q  <= (stat_q & ~stat_clr) | trig;
      wstat_q <= (wstat_q & ~wstat_clr) | (trig & wmask_q);
    end
  end

  always_comb begin
    case (grp)
      GRP_LEVEL: rdata = lvl & VALID;
      GRP_DIR:   rdata = dir_q;
      GRP_RISE:  rdata = rise_q;
      GRP_FALL:  rdata = fall_q;
      GRP_BYP:   rdata = byp_q;
      GRP_MASK:  rdata = mask_q;
      GRP_STAT:  rdata = stat_q;
      GRP_TYPE:  rdata = type_q;
      GRP_POL:   rdata = pol_q;
      GRP_WMASK: rdata = wmask_q;
      GRP_WSTAT: rdata = wstat_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam int WORDS = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int PADW  = WORDS * REG_W;

  logic [PADW-1:0]  pin_pad, lvl_flat, lvl_prev_flat, dir_flat, out_flat, mask_flat;
  logic [REG_W-1:0] word_rd [WORDS];
  logic [WORDS-1:0] word_irq;
  logic [REG_W-1:0] cfg_q, rd_sel;
  dec_t             dec;

  assign pin_pad = PADW'(pin_in);
  assign dec     = decode_addr(bus_addr, WORDS);

  gpio_sync #(.W(PADW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_pad), .q(lvl_flat), .q_prev(lvl_prev_flat)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int NV = (NUM_PINS - REG_W * w > REG_W) ? REG_W : NUM_PINS - REG_W * w;
    localparam logic [REG_W-1:0] VM = (NV == REG_W) ? '1 : ((32'd1 << NV) - 32'd1);
    logic wr_w;
    assign wr_w = bus_sel && bus_wr && dec.hit && (dec.word == 3'(w));
    gpio_word #(.VALID(VM)) u_word (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_w), .grp(dec.grp), .wdata(bus_wdata),
      .lvl(lvl_flat[REG_W*w +: REG_W]), .lvl_prev(lvl_prev_flat[REG_W*w +: REG_W]),
      .rdata(word_rd[w]), .dir_q(dir_flat[REG_W*w +: REG_W]),
      .out_q(out_flat[REG_W*w +: REG_W]), .mask_q(mask_flat[REG_W*w +: REG_W]),
      .irq_any(word_irq[w])
    );
  end

  always_comb begin
    rd_sel = '0;
    if (bus_addr == OFS_CFG) rd_sel = cfg_q;
    else if (dec.hit)
      for (int w = 0; w < WORDS; w++)
        if (dec.word == 3'(w)) rd_sel = word_rd[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == OFS_CFG) cfg_q <= bus_wdata;
      if (bus_sel && !bus_wr) bus_rdata <= rd_sel;
    end
  end

  assign pin_out = out_flat[NUM_PINS-1:0];
  assign pin_oe  = dir_flat[NUM_PINS-1:0];
  assign irq_out = |word_irq;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int NUM_PINS = 64,
  parameter int PADW     = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [11:0]         bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq_out,
  input logic [PADW-1:0]     mask_flat
);
  logic dir_wr, set0_wr, clr0_wr;
  assign dir_wr  = bus_sel && bus_wr && bus_addr >= 12'h01c && bus_addr < 12'h034;
  assign set0_wr = bus_sel && bus_wr && bus_addr == 12'h034 && bus_wdata[0];
  assign clr0_wr = bus_sel && bus_wr && bus_addr == 12'h04c && bus_wdata[0];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq_out));
  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));
  // R3
  set_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set0_wr |=> pin_out[0]);
  // R3
  clr_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr0_wr |=> !pin_out[0]);
  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_flat != '0));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NUM_PINS(NUM_PINS), .PADW(PADW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq_out(irq_out), .mask_flat(mask_flat)
);

// File: tb/gpio_bank_irq_test.sv
module gpio_bank_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic          irq_out;
  int            errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_irq #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  task automatic clean();
    pin_in = '0;
    settle();
    for (int k = 0; k < 2; k++) begin
      wr(12'h064 + 12'(4*k), 0); wr(12'h07c + 12'(4*k), 0);
      wr(12'h300 + 12'(4*k), 0); wr(12'h318 + 12'(4*k), 0);
      wr(12'h0ac + 12'(4*k), 0); wr(12'h400 + 12'(4*k), 0);
      wr(12'h0c4 + 12'(4*k), 32'hFFFF_FFFF); wr(12'h418 + 12'(4*k), 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    // R1 outputs during reset
    chk("R1 oe in reset", 64'(pin_oe), 64'd0);
    chk("R1 irq in reset", 64'(irq_out), 64'd0);
    rst_n = 1'b1;
    rd_chk("R1 dir", 12'h01c, 0);
    rd_chk("R1 mask", 12'h0ac, 0);
    rd_chk("R1 status", 12'h0c4, 0);
    rd_chk("R1 type", 12'h300, 0);
    chk("R1 out", 64'(pin_out), 64'd0);
  endtask

  task automatic t_dir_out();
    wr(12'h01c, 32'h0000_00F0);
    // R2 output enable follows direction
    chk("R2 oe", 64'(pin_oe), 64'h0000_0000_0000_00F0);
    wr(12'h034, 32'h30);
    chk("R3 set", 64'(pin_out), 64'h30);
    wr(12'h034, 32'h01);
    chk("R3 set keeps others", 64'(pin_out), 64'h31);
    wr(12'h04c, 32'h10);
    chk("R3 clear", 64'(pin_out), 64'h21);
    rd_chk("R3 set word reads 0", 12'h034, 0);
    rd_chk("R3 clear word reads 0", 12'h04c, 0);
    wr(12'h04c, 32'hFFFF_FFFF);
    wr(12'h01c, 0);
    chk("R2 oe back to input", 64'(pin_oe), 64'd0);
  endtask

  task automatic t_level_read();
    pin_in[3] = 1'b1; pin_in[35] = 1'b1;
    settle();
    rd_chk("R4 level word0", 12'h004, 32'h8);
    rd_chk("R4 level word1", 12'h008, 32'h8);
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R4 level write ignored", 12'h004, 32'h8);
    clean();
  endtask

  task automatic t_edges();
    wr(12'h064, 32'h0000_000C);
    pin_in[5] = 1'b1;
    settle();
    rd_chk("R6 no enable no status", 12'h0c4, 0);
    pin_in[3] = 1'b1; pin_in[2] = 1'b1;
    settle();
    rd_chk("R5 rising sets status", 12'h0c4, 32'hC);
    wr(12'h0c4, 32'h4);
    rd_chk("R8 w1c keeps others", 12'h0c4, 32'h8);
    wr(12'h0ac, 32'h4);
    chk("R9 mask other bit irq low", 64'(irq_out), 64'd0);
    wr(12'h0ac, 32'h8);
    chk("R9 masked status raises irq", 64'(irq_out), 64'd1);
    wr(12'h0c4, 32'h8);
    chk("R9 cleared status drops irq", 64'(irq_out), 64'd0);
    pin_in[3] = 1'b0;
    settle();
    rd_chk("R6 falling without enable", 12'h0c4, 0);
    clean();
  endtask

  task automatic t_word1();
    wr(12'h068, 32'h10); wr(12'h080, 32'h10);
    pin_in[36] = 1'b1;
    settle();
    rd_chk("R11 pin36 in word1", 12'h0c8, 32'h10);
    rd_chk("R11 word0 untouched", 12'h0c4, 0);
    wr(12'h0c8, 32'h10);
    pin_in[36] = 1'b0;
    settle();
    rd_chk("R5 both edges falling", 12'h0c8, 32'h10);
    clean();
  endtask

  task automatic t_level_mode();
    wr(12'h300, 32'h40);
    settle();
    rd_chk("R7 inactive level no status", 12'h0c4, 0);
    pin_in[6] = 1'b1;
    settle();
    rd_chk("R7 high level sets", 12'h0c4, 32'h40);
    wr(12'h0c4, 32'h40);
    rd_chk("R7 clear ignored while active", 12'h0c4, 32'h40);
    pin_in[6] = 1'b0;
    settle();
    rd_chk("R7 sticky after level ends", 12'h0c4, 32'h40);
    wr(12'h0c4, 32'h40);
    rd_chk("R8 clear after level ends", 12'h0c4, 0);
    wr(12'h318, 32'h40);
    rd_chk("R7 low polarity triggers", 12'h0c4, 32'h40);
    pin_in[6] = 1'b1;
    settle();
    wr(12'h0c4, 32'h40);
    rd_chk("R7 low polarity idle when high", 12'h0c4, 0);
    clean();
  endtask

  task automatic t_wake();
    wr(12'h064, 32'hC);
    wr(12'h400, 32'h4);
    pin_in[2] = 1'b1; pin_in[3] = 1'b1;
    settle();
    rd_chk("R10 wake only masked pin", 12'h418, 32'h4);
    wr(12'h418, 32'h4);
    rd_chk("R10 wake cleared", 12'h418, 0);
    clean();
  endtask

  task automatic t_store();
    wr(12'h000, 32'hA5A5_5A5A);
    rd_chk("R12 config", 12'h000, 32'hA5A5_5A5A);
    wr(12'h098, 32'h1234_5678);
    rd_chk("R12 bypass word1", 12'h098, 32'h1234_5678);
  endtask

  initial begin
    t_reset();
    t_dir_out();
    t_level_read();
    t_edges();
    t_word1();
    t_level_mode();
    t_wake();
    t_store();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule